// File: doc/BRIEF.md
# Flash Block-Protection Decoder

This block decides, one request at a time, whether a program or erase aimed at a 24-bit address of a serial flash array must be refused. The array holds 8,388,608 bytes. It is split into 128 sectors of 64 KB, each sector made of sixteen 4 KB subsectors, and each subsector made of sixteen 256-byte pages. Protection is decided per sector. A three-bit protect level sets how many sectors are locked. A placement bit sets whether that locked span starts at the highest addresses or at the lowest. A bulk erase is judged on the whole array and not on one address.

The block also combines a lock bit from the status register with an active-low write-protect pin. When both are asserted, the block reports a hardware lock and forbids status-register writes. The command decoder and the non-volatile storage of the configuration bits sit outside this block. The decoder registers every answer, so the result appears one clock after the request.

Top module: `flash_prot_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `result_valid`, `result_deny`, `sr_write_ok` and `hw_locked` are all 0.
- R2: `result_valid` equals the value `chk_valid` had one clock earlier. `result_deny` gives the verdict for the request and configuration sampled at that same edge.
- R3: With protect level `cfg_bp` = 0, no request is denied, including a bulk erase.
- R4: With `cfg_top_bot` = 0 (top placement) and `cfg_bp` = n in 1..6, a program or erase is denied exactly when its sector index, address bits 22:16, is at least 128 − 2^n. Level 1 therefore locks sectors 126 and 127.
- R5: With `cfg_top_bot` = 1 (bottom placement) and `cfg_bp` = n in 1..6, a program or erase is denied exactly when the sector index is below 2^n.
- R6: With `cfg_bp` = 7, every program or erase is denied for both placements.
- R7: `chk_op` is encoded as 0 = page program, 1 = subsector erase, 2 = sector erase, 3 = bulk erase. A bulk erase is denied exactly when `cfg_bp` is nonzero, whatever the address.
- R8: For codes 0, 1 and 2, the verdict depends only on address bits 22:16. Bit 23 and bits 15:0 have no effect, and all three codes give the same verdict for the same address.
- R9: One clock after `cfg_srwd` = 1 and `wp_n` = 0 are sampled, `hw_locked` is 1 and `sr_write_ok` is 0. For any other combination of those two inputs, `hw_locked` is 0 and `sr_write_ok` is 1.
- R10: `result_deny` is 0 whenever `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bp | input | 3 | Protect level; 0 = none, each step doubles the locked span, 7 = all |
| cfg_top_bot | input | 1 | Span placement: 0 = from top of array, 1 = from bottom |
| cfg_srwd | input | 1 | Status-register lock bit |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_valid | input | 1 | A request is present this cycle |
| chk_op | input | 2 | Operation code, see R7 |
| chk_addr | input | 24 | Byte address of the request |
| result_valid | output | 1 | Verdict present (one cycle after request) |
| result_deny | output | 1 | 1 = the request must be refused |
| sr_write_ok | output | 1 | Status-register writes are allowed |
| hw_locked | output | 1 | Hardware protection is in force |

## Verification
The hardest cases to reach are the boundaries of the locked span. These are the single sector just inside and just outside the span, for each level and for each placement. A random address lands on one of them only about once in 64 draws. The stimulus therefore targets them directly: for every level and both placements it drives the first and last byte of each boundary sector. Random requests run alongside these, with random high and low address bits, so the tests also show that those bits are ignored.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SSE  = 2'd1,
        OP_SE   = 2'd2,
        OP_BULK = 2'd3
    } fpd_op_e;

    typedef struct packed {
        logic valid;
        logic deny;
        logic sr_ok;
        logic locked;
    } fpd_state_t;

endpackage

// File: rtl/fpd_span.sv
// Turns protect level and placement into a half-open sector span [lo, hi).
module fpd_span #(
    parameter int SECT_W = 7,
    parameter int BP_W   = 3
) (
    input  logic [BP_W-1:0]  bp,
    input  logic             top_bot,
    output logic [SECT_W:0]  lo,
    output logic [SECT_W:0]  hi,
    output logic             any
);
    localparam logic [SECT_W:0] ONE  = 1;
    localparam logic [SECT_W:0] FULL = ONE << SECT_W;

    logic [SECT_W:0] cnt;

    always_comb begin
        if (bp == '0) begin
            cnt = '0;
        end else if (int'(bp) >= SECT_W) begin
            cnt = FULL;
        end else begin
            cnt = ONE << bp;
        end
        any = (bp != '0);
        if (top_bot) begin
            lo = '0;
            hi = cnt;
        end else begin
            lo = FULL - cnt;
            hi = FULL;
        end
    end
endmodule

// File: rtl/fpd_match.sv
// Compares one sector index or a whole-array operation against the span.
module fpd_match #(
    parameter int SECT_W = 7
) (
    input  fpd_pkg::fpd_op_e   op,
    input  logic [SECT_W-1:0]  sector,
    input  logic [SECT_W:0]    lo,
    input  logic [SECT_W:0]    hi,
    input  logic               any,
    output logic               deny
);
    logic [SECT_W:0] sec_x;

    always_comb begin
        sec_x = {1'b0, sector};
        if (op == fpd_pkg::OP_BULK) begin
            deny = any;
        end else begin
            deny = (sec_x >= lo) && (sec_x < hi);
        end
    end
endmodule

// File: rtl/fpd_srlock.sv
// Hardware lock: register bit set and write-protect pin pulled low.
module fpd_srlock (
    input  logic srwd,
    input  logic wp_n,
    output logic locked
);
    always_comb begin
        locked = srwd && !wp_n;
    end
endmodule

// File: rtl/flash_prot_decoder.sv
module flash_prot_decoder #(
    parameter int ADDR_W   = 24,
    parameter int SECT_W   = 7,
    parameter int SECT_LSB = 16,
    parameter int BP_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BP_W-1:0]   cfg_bp,
    input  logic              cfg_top_bot,
    input  logic              cfg_srwd,
    input  logic              wp_n,
    input  logic              chk_valid,
    input  logic [1:0]        chk_op,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              result_valid,
    output logic              result_deny,
    output logic              sr_write_ok,
    output logic              hw_locked
);
    import fpd_pkg::*;

    localparam int SECT_MSB = SECT_LSB + SECT_W - 1;

    fpd_state_t st_d, st_q;

    logic [SECT_W-1:0] sector;
    logic [SECT_W:0]   span_lo, span_hi;
    logic              span_any;
    logic              hit;
    logic              lock_now;
    logic              unused_addr;

    assign sector      = chk_addr[SECT_MSB:SECT_LSB];
    assign unused_addr = ^{chk_addr[ADDR_W-1:SECT_MSB+1], chk_addr[SECT_LSB-1:0]};

    fpd_span #(.SECT_W(SECT_W), .BP_W(BP_W)) u_span (
        .bp      (cfg_bp),
        .top_bot (cfg_top_bot),
        .lo      (span_lo),
        .hi      (span_hi),
        .any     (span_any)
    );

    fpd_match #(.SECT_W(SECT_W)) u_match (
        .op     (fpd_op_e'(chk_op)),
        .sector (sector),
        .lo     (span_lo),
        .hi     (span_hi),
        .any    (span_any),
        .deny   (hit)
    );

    fpd_srlock u_lock (
        .srwd   (cfg_srwd),
        .wp_n   (wp_n),
        .locked (lock_now)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = chk_valid;
        st_d.deny   = chk_valid && hit;
        st_d.locked = lock_now;
        st_d.sr_ok  = !lock_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_valid = st_q.valid;
    assign result_deny  = st_q.deny;
    assign sr_write_ok  = st_q.sr_ok;
    assign hw_locked    = st_q.locked;
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
    parameter int BP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [BP_W-1:0] cfg_bp,
    input logic            cfg_srwd,
    input logic            wp_n,
    input logic            chk_valid,
    input logic [1:0]      chk_op,
    input logic            result_valid,
    input logic            result_deny,
    input logic            sr_write_ok,
    input logic            hw_locked
);
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R1: outputs clear during reset
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (!result_valid && !result_deny && !sr_write_ok && !hw_locked);
        end
    end

    a_r2_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        result_valid == $past(chk_valid));

    a_r10_idle_no_deny: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        !result_valid |-> !result_deny);

    a_r9_lock_from_pins: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        hw_locked == $past(cfg_srwd && !wp_n));

    a_r9_sr_ok_when_pin_high: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        $past(wp_n) |-> sr_write_ok);

    a_r3_level_zero_open: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        $past(chk_valid && cfg_bp == '0) |-> !result_deny);

    a_r6_level_max_all: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        $past(chk_valid && cfg_bp == {BP_W{1'b1}}) |-> result_deny);

    a_r7_bulk_guarded: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        $past(chk_valid && chk_op == 2'd3) |-> (result_deny == $past(cfg_bp != '0)));
endmodule

bind flash_prot_decoder fpd_checker #(.BP_W(BP_W)) u_fpd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_bp       (cfg_bp),
    .cfg_srwd     (cfg_srwd),
    .wp_n         (wp_n),
    .chk_valid    (chk_valid),
    .chk_op       (chk_op),
    .result_valid (result_valid),
    .result_deny  (result_deny),
    .sr_write_ok  (sr_write_ok),
    .hw_locked    (hw_locked)
);

// File: tb/flash_prot_decoder_bench.sv
module flash_prot_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_bp = '0;
    logic        cfg_top_bot = 1'b0;
    logic        cfg_srwd = 1'b0;
    logic        wp_n = 1'b1;
    logic        chk_valid = 1'b0;
    logic [1:0]  chk_op = '0;
    logic [23:0] chk_addr = '0;
    logic        result_valid, result_deny, sr_write_ok, hw_locked;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_prot_decoder u_flash_prot_decoder (
        .clk, .rst_n, .cfg_bp, .cfg_top_bot, .cfg_srwd, .wp_n,
        .chk_valid, .chk_op, .chk_addr,
        .result_valid, .result_deny, .sr_write_ok, .hw_locked
    );

    function automatic bit exp_deny(input logic [2:0] bp, input logic tb,
                                    input logic [1:0] op, input logic [23:0] a);
        int cnt, s;
        if (op == 2'd3) return bp != 0;
        if (bp == 0) return 1'b0;
        cnt = (bp == 3'd7) ? 128 : (1 << bp);
        s = int'(a[22:16]);
        return tb ? (s < cnt) : (s >= 128 - cnt);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [2:0] bp, input logic tb,
                         input logic [1:0] op, input logic [23:0] a);
        @(negedge clk);
        cfg_bp = bp; cfg_top_bot = tb; chk_op = op; chk_addr = a; chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
        check({req, " valid"}, int'(result_valid), 1);
        check({req, " deny"}, int'(result_deny), int'(exp_deny(bp, tb, op, a)));
    endtask

    initial begin
        #1;
        // R1: reset state
        check("R1 valid", int'(result_valid), 0);
        check("R1 deny", int'(result_deny), 0);
        check("R1 sr_ok", int'(sr_write_ok), 0);
        check("R1 locked", int'(hw_locked), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release valid", int'(result_valid), 0);

        // R3: level zero leaves everything open
        probe("R3 top sector", 3'd0, 1'b0, 2'd2, 24'h7F0000);
        probe("R3 bulk", 3'd0, 1'b1, 2'd3, 24'h000000);

        // R4 / R5: boundary sectors for every level and both placements
        for (int lv = 1; lv <= 6; lv++) begin
            int edge_t, edge_b;
            edge_t = 128 - (1 << lv);
            edge_b = (1 << lv);
            probe("R4 inside", 3'(lv), 1'b0, 2'd0, {1'b0, 7'(edge_t), 16'h0000});
            probe("R4 outside", 3'(lv), 1'b0, 2'd1, {1'b0, 7'(edge_t - 1), 16'hFFFF});
            probe("R5 inside", 3'(lv), 1'b1, 2'd2, {1'b0, 7'(edge_b - 1), 16'hFFFF});
            probe("R5 outside", 3'(lv), 1'b1, 2'd0, {1'b0, 7'(edge_b), 16'h0000});
        end
        probe("R4 level1 sector125", 3'd1, 1'b0, 2'd0, 24'h7DFFFF);
        probe("R4 level1 sector126", 3'd1, 1'b0, 2'd0, 24'h7E0000);

        // R6: full array
        probe("R6 bottom addr top place", 3'd7, 1'b0, 2'd1, 24'h000000);
        probe("R6 top addr bottom place", 3'd7, 1'b1, 2'd2, 24'h7FFFFF);

        // R7: bulk erase ignores address
        probe("R7 bulk unprotected-addr", 3'd1, 1'b0, 2'd3, 24'h000123);
        probe("R7 bulk level0", 3'd0, 1'b0, 2'd3, 24'h7F0000);

        // R8: bit 23 and low bits ignored; codes agree
        probe("R8 bit23 set", 3'd2, 1'b0, 2'd0, 24'hFC1234);
        probe("R8 bit23 clear", 3'd2, 1'b0, 2'd1, 24'h7C8765);
        probe("R8 bit23 outside", 3'd2, 1'b0, 2'd2, 24'hFBFFFF);

        // R10: idle cycle gives no deny
        @(negedge clk);
        cfg_bp = 3'd7; chk_valid = 1'b0;
        @(negedge clk);
        check("R10 idle valid", int'(result_valid), 0);
        check("R10 idle deny", int'(result_deny), 0);

        // R9: every srwd / pin combination
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_srwd = k[1]; wp_n = k[0];
            @(negedge clk);
            check("R9 locked", int'(hw_locked), int'(k == 2));
            check("R9 sr_ok", int'(sr_write_ok), int'(k != 2));
        end

        // R2: random requests, some idle, all checked against the model
        void'($urandom(32'h5A17));
        for (int i = 0; i < 600; i++) begin
            logic [2:0] bp; logic tb, v; logic [1:0] op; logic [23:0] a;
            bp = 3'($urandom); tb = 1'($urandom); op = 2'($urandom);
            a = 24'($urandom); v = ($urandom % 4) != 0;
            @(negedge clk);
            cfg_bp = bp; cfg_top_bot = tb; chk_op = op; chk_addr = a; chk_valid = v;
            cfg_srwd = 1'($urandom); wp_n = 1'($urandom);
            @(negedge clk);
            check("R2 random valid", int'(result_valid), int'(v));
            check("R2 random deny", int'(result_deny), int'(v && exp_deny(bp, tb, op, a)));
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule